// File: doc/BRIEF.md
# Buck Converter Fault Supervisor with Hiccup Sequencing

This block is the digital supervisor of a synchronous step-down regulator. Comparator results reach it already digitized: enable, supply-undervoltage-lockout clear, feedback above the overvoltage level, feedback below the undervoltage level, an external temperature trip and an on-die thermal trip. It also receives an over-current hiccup request from the current-limit logic and a flag that marks the end of the soft-start ramp. From these it decides whether the power switches may operate, whether the low-side switch must be held on, when a new soft-start ramp begins, and whether the output is reported as good.

Every fault leads to a wait with both switches off, and the wait ends in a new soft-start. Overvoltage and undervoltage must persist through a blanking window before they count, and they are only monitored once the ramp has finished. An overvoltage first clamps the output through the low-side switch and only starts the wait once the output has fallen below the undervoltage level. The length of the wait is four soft-start periods, but never less than a fixed floor. All time constants derive from a clock-frequency parameter. The soft-start length comes in on a port as a clock-cycle count.

Top module: `buck_fault_supervisor`

## Requirements
- R1: When `en_i` is low or `uvlo_ok_i` is low, the block returns to idle at the next clock edge, from any state. In idle, `hs_en_o`, `ls_en_o`, `ls_force_o` and `pgood_o` are all 0. The same outputs are 0 after reset.
- R2: When the block is enabled from idle with both thermal flags clear, `ss_start_o` is 1 for exactly one cycle. That is the first cycle of soft-start, in which `hs_en_o` and `ls_en_o` are 1 and `pgood_o` is 0.
- R3: An over-current request during soft-start or regulation turns both switches off at the next edge. Overvoltage and undervoltage flags have no effect during soft-start.
- R4: During regulation, an overvoltage or undervoltage flag latches only after it is sampled high on BLANK_CYC consecutive clock edges (20 µs of clock). A shorter assertion leaves the switches running.
- R5: A latched overvoltage sets `hs_en_o`=0, `ls_en_o`=1, `ls_force_o`=1 and `pgood_o`=0. This hold lasts while `uv_i` is low. The edge that samples `uv_i` high starts the hiccup wait with all switches off.
- R6: A latched undervoltage starts the hiccup wait at once, with all switches off.
- R7: The hiccup wait lasts exactly max(4 × `ss_len_i`, FLOOR_CYC) cycles. On the cycle after the wait, `ss_start_o` pulses and soft-start begins.
- R8: If `ss_len_i` is below one millisecond of clock cycles (including 0), the wait equals the 4 ms floor. From one millisecond upward, the wait is 4 × `ss_len_i`.
- R9: While `ot_ext_i` or `tsd_i` is high and the block is enabled, both switches are off. On the first edge where both flags are low, a soft-start pulse is issued.
- R10: `pgood_o` is 1 only during regulation, and only while both `ov_i` and `uv_i` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable comparator result |
| uvlo_ok_i | input | 1 | Supply above undervoltage-lockout level |
| ov_i | input | 1 | Feedback above overvoltage level |
| uv_i | input | 1 | Feedback below undervoltage level |
| ot_ext_i | input | 1 | External temperature comparator (hysteresis applied upstream) |
| tsd_i | input | 1 | On-die thermal shutdown flag |
| ocp_hiccup_i | input | 1 | Over-current hiccup request |
| ss_done_i | input | 1 | Soft-start ramp complete |
| ss_len_i | input | SS_W | Soft-start duration in clock cycles |
| hs_en_o | output | 1 | High-side switch permitted |
| ls_en_o | output | 1 | Low-side switch permitted |
| ls_force_o | output | 1 | Hold low-side switch on |
| ss_start_o | output | 1 | One-cycle soft-start restart pulse |
| pgood_o | output | 1 | Power good (1 = released) |

## Verification
The bound checker watches these rules on every cycle: disable forces everything off, the thermal flags block the switches, over-current stops the high side, a blanking trip leads into the clamp, the end of a wait produces a restart pulse, and power-good never coexists with the clamp. Several properties can only be seen in the bench's scenarios: the exact length of the blanking window, the exact hiccup wait for soft-start lengths on both sides of the millisecond boundary, the overvoltage clamp holding until the output falls, and flags being ignored during the ramp. Each of these is measured there by counting cycles.

// File: rtl/buck_sup_pkg.sv
`timescale 1ns/1ps
package buck_sup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RAMP  = 3'd1,
    ST_REG   = 3'd2,
    ST_CLAMP = 3'd3,
    ST_WAIT  = 3'd4,
    ST_HOT   = 3'd5
  } sup_state_t;

  // Clock cycles covering a span given in microseconds.
  function automatic int unsigned cycles_for_us(int unsigned clk_hz, int unsigned usec);
    logic [63:0] prod;
    prod = ({32'd0, clk_hz} * {32'd0, usec}) / 64'd1000000;
    return prod[31:0];
  endfunction

  // Hiccup wait: four ramp lengths, or the floor for short ramps.
  function automatic int unsigned hiccup_wait(int unsigned ss_len, int unsigned ms_cyc,
                                              int unsigned floor_cyc);
    if (ss_len < ms_cyc) return floor_cyc;
    return ss_len * 4;
  endfunction

endpackage

// File: rtl/fault_blanker.sv
`timescale 1ns/1ps
module fault_blanker #(
  parameter int unsigned N = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic flag_i,
  output logic trip_o
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] run_cnt;

  assign trip_o = arm_i && flag_i && (run_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!arm_i || !flag_i) begin
      run_cnt <= '0;
    end else if (run_cnt != LAST) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hiccup_timer.sv
`timescale 1ns/1ps
module hiccup_timer #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] elapsed;

  assign done_o = run_i && (elapsed == limit_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
    end else if (!run_i) begin
      elapsed <= '0;
    end else begin
      elapsed <= elapsed + 1'b1;
    end
  end
endmodule

// File: rtl/buck_fault_supervisor.sv
`timescale 1ns/1ps
module buck_fault_supervisor
  import buck_sup_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned BLANK_US = 20,
  parameter int unsigned FLOOR_US = 4000,
  parameter int          SS_W     = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            uvlo_ok_i,
  input  logic            ov_i,
  input  logic            uv_i,
  input  logic            ot_ext_i,
  input  logic            tsd_i,
  input  logic            ocp_hiccup_i,
  input  logic            ss_done_i,
  input  logic [SS_W-1:0] ss_len_i,
  output logic            hs_en_o,
  output logic            ls_en_o,
  output logic            ls_force_o,
  output logic            ss_start_o,
  output logic            pgood_o
);
  localparam int unsigned BLANK_CYC = cycles_for_us(CLK_HZ, BLANK_US);
  localparam int unsigned MS_CYC    = cycles_for_us(CLK_HZ, 1000);
  localparam int unsigned FLOOR_CYC = cycles_for_us(CLK_HZ, FLOOR_US);
  localparam int FLOOR_W = $clog2(FLOOR_CYC + 1);
  localparam int WAIT_W  = (SS_W + 2 > FLOOR_W) ? SS_W + 2 : FLOOR_W;
  localparam int NMON    = 2;

  sup_state_t st_q, st_d;
  logic       pulse_d, pulse_q;

  // Named internal events (observed by the bound checker).
  logic            active;
  logic            hot;
  logic            ov_trip, uv_trip;
  logic            hiccup_done;
  logic [NMON-1:0] mon_flags, mon_trips;
  logic [WAIT_W-1:0] wait_lim;

  assign active = en_i && uvlo_ok_i;
  assign hot    = ot_ext_i || tsd_i;

  // Overvoltage and undervoltage blanking, armed only in regulation.
  assign mon_flags = {uv_i, ov_i};
  generate
    for (genvar gi = 0; gi < NMON; gi++) begin : g_mon
      fault_blanker #(.N(BLANK_CYC)) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (st_q == ST_REG),
        .flag_i (mon_flags[gi]),
        .trip_o (mon_trips[gi])
      );
    end
  endgenerate
  assign ov_trip = mon_trips[0];
  assign uv_trip = mon_trips[1];

  assign wait_lim = WAIT_W'(hiccup_wait(32'(ss_len_i), MS_CYC, FLOOR_CYC));

  hiccup_timer #(.W(WAIT_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (st_q == ST_WAIT),
    .limit_i (wait_lim),
    .done_o  (hiccup_done)
  );

  always_comb begin
    st_d    = st_q;
    pulse_d = 1'b0;
    if (!active) begin
      st_d = ST_IDLE;
    end else if (hot) begin
      st_d = ST_HOT;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_HOT: begin
          st_d    = ST_RAMP;
          pulse_d = 1'b1;
        end
        ST_RAMP: begin
          if (ocp_hiccup_i)   st_d = ST_WAIT;
          else if (ss_done_i) st_d = ST_REG;
        end
        ST_REG: begin
          if (ocp_hiccup_i)  st_d = ST_WAIT;
          else if (ov_trip)  st_d = ST_CLAMP;
          else if (uv_trip)  st_d = ST_WAIT;
        end
        ST_CLAMP: begin
          if (uv_i) st_d = ST_WAIT;
        end
        ST_WAIT: begin
          if (hiccup_done) begin
            st_d    = ST_RAMP;
            pulse_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= pulse_d;
    end
  end

  assign hs_en_o    = (st_q == ST_RAMP) || (st_q == ST_REG);
  assign ls_en_o    = hs_en_o || (st_q == ST_CLAMP);
  assign ls_force_o = (st_q == ST_CLAMP);
  assign ss_start_o = pulse_q;
  assign pgood_o    = (st_q == ST_REG) && !ov_i && !uv_i;

endmodule

// File: rtl/buck_sup_checker.sv
`timescale 1ns/1ps
module buck_sup_checker (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic uvlo_ok_i,
  input logic ov_i,
  input logic uv_i,
  input logic ot_ext_i,
  input logic tsd_i,
  input logic ocp_hiccup_i,
  input logic hs_en_o,
  input logic ls_en_o,
  input logic ls_force_o,
  input logic ss_start_o,
  input logic pgood_o,
  input logic ov_trip,
  input logic hiccup_done
);
  logic ok_run;
  assign ok_run = en_i && uvlo_ok_i && !ot_ext_i && !tsd_i;

  p_disable_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || !uvlo_ok_i) |=> (!hs_en_o && !ls_en_o && !pgood_o));

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start_o |=> !ss_start_o);

  p_pulse_ramp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start_o |-> (hs_en_o && !pgood_o));

  p_ocp_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en_o && ocp_hiccup_i && ok_run) |=> (!hs_en_o && !ls_en_o));

  p_clamp_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_trip && ok_run && !ocp_hiccup_i) |=> (ls_force_o && ls_en_o && !hs_en_o));

  p_clamp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_force_o && !uv_i && ok_run) |=> ls_force_o);

  p_wait_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hiccup_done && ok_run) |=> ss_start_o);

  p_thermal_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && uvlo_ok_i && (ot_ext_i || tsd_i)) |=> (!hs_en_o && !ls_en_o));

  p_pg_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_o |-> (hs_en_o && !ls_force_o && !ov_i && !uv_i));

endmodule

bind buck_fault_supervisor buck_sup_checker u_sup_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .uvlo_ok_i    (uvlo_ok_i),
  .ov_i         (ov_i),
  .uv_i         (uv_i),
  .ot_ext_i     (ot_ext_i),
  .tsd_i        (tsd_i),
  .ocp_hiccup_i (ocp_hiccup_i),
  .hs_en_o      (hs_en_o),
  .ls_en_o      (ls_en_o),
  .ls_force_o   (ls_force_o),
  .ss_start_o   (ss_start_o),
  .pgood_o      (pgood_o),
  .ov_trip      (ov_trip),
  .hiccup_done  (hiccup_done)
);

// File: tb/test_buck_fault_supervisor.sv
`timescale 1ns/1ps
module test_buck_fault_supervisor;
  localparam int unsigned CLK_HZ = 1_000_000;  // count basis: 1 cycle = 1 us
  localparam int SS_W  = 24;
  localparam int BLANK = 20;                  // 20 us
  localparam int NTAB  = 6;
  // soft-start length, expected hiccup wait (R7, R8)
  localparam int HIC_TAB [NTAB][2] = '{
    '{0, 4000}, '{500, 4000}, '{999, 4000},
    '{1000, 4000}, '{1001, 4004}, '{1500, 6000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 0, uvlo_ok_i = 0, ov_i = 0, uv_i = 0, ot_ext_i = 0, tsd_i = 0;
  logic ocp_hiccup_i = 0, ss_done_i = 0;
  logic [SS_W-1:0] ss_len_i = 24'd200;
  logic hs_en_o, ls_en_o, ls_force_o, ss_start_o, pgood_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  buck_fault_supervisor #(.CLK_HZ(CLK_HZ), .SS_W(SS_W)) i_buck_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_ok_i(uvlo_ok_i), .ov_i(ov_i),
    .uv_i(uv_i), .ot_ext_i(ot_ext_i), .tsd_i(tsd_i), .ocp_hiccup_i(ocp_hiccup_i),
    .ss_done_i(ss_done_i), .ss_len_i(ss_len_i), .hs_en_o(hs_en_o), .ls_en_o(ls_en_o),
    .ls_force_o(ls_force_o), .ss_start_o(ss_start_o), .pgood_o(pgood_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Counts wait cycles until the restart pulse is seen.
  task automatic wait_ss(output int n);
    n = 0;
    while (!ss_start_o && n < 20000) begin
      n++;
      tick();
    end
  endtask

  task automatic to_reg();
    ss_done_i = 1;
    tick();
    ss_done_i = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int n;
    ticks(3);
    chk("R1 reset hs", hs_en_o, 0);
    chk("R1 reset ls", ls_en_o + ls_force_o + pgood_o + ss_start_o, 0);
    rst_n = 1;
    tick();

    // Table-driven hiccup wait (R7, R8)
    en_i = 1; uvlo_ok_i = 1;
    tick();
    for (int k = 0; k < NTAB; k++) begin
      ss_len_i = SS_W'(HIC_TAB[k][0]);
      ocp_hiccup_i = 1;
      tick();
      ocp_hiccup_i = 0;
      wait_ss(n);
      chk($sformatf("R7 R8 wait for ss_len %0d", HIC_TAB[k][0]), n, HIC_TAB[k][1]);
    end
    ss_len_i = 24'd200;

    // Fresh enable (R2)
    en_i = 0;
    tick();
    en_i = 1;
    tick();
    chk("R2 pulse", ss_start_o, 1);
    chk("R2 gates", hs_en_o + ls_en_o, 2);
    chk("R2 pg low in ramp", pgood_o, 0);
    tick();
    chk("R2 pulse single", ss_start_o, 0);

    // Flags ignored during ramp (R3)
    ov_i = 1; uv_i = 1;
    ticks(30);
    chk("R3 ov/uv ignored in ramp", hs_en_o + 2 * ls_force_o, 1);
    ov_i = 0; uv_i = 0;
    to_reg();
    chk("R10 pg in regulation", pgood_o, 1);

    // Short overvoltage (R4, R10)
    ov_i = 1;
    ticks(BLANK - 1);
    chk("R10 pg low while ov", pgood_o, 0);
    chk("R4 short ov no clamp", ls_force_o, 0);
    ov_i = 0;
    tick();
    chk("R4 short ov still running", hs_en_o + pgood_o, 2);

    // Full overvoltage, clamp, then hiccup (R4, R5, R7)
    ov_i = 1;
    ticks(BLANK - 1);
    chk("R4 no clamp before window", ls_force_o, 0);
    tick();
    chk("R5 clamp force", ls_force_o + ls_en_o, 2);
    chk("R5 clamp hs off pg low", hs_en_o + pgood_o, 0);
    ov_i = 0;
    ticks(10);
    chk("R5 clamp held", ls_force_o, 1);
    uv_i = 1;
    tick();
    chk("R5 release to wait", ls_force_o + ls_en_o + hs_en_o, 0);
    uv_i = 0;
    wait_ss(n);
    chk("R7 wait after clamp", n, 4000);

    // Over-current during ramp (R3)
    ocp_hiccup_i = 1;
    tick();
    chk("R3 ocp in ramp", hs_en_o + ls_en_o, 0);
    ocp_hiccup_i = 0;
    wait_ss(n);
    chk("R7 wait after ocp", n, 4000);

    // Undervoltage in regulation (R6)
    to_reg();
    uv_i = 1;
    ticks(BLANK - 1);
    chk("R6 uv not yet", hs_en_o, 1);
    tick();
    chk("R6 uv to wait", hs_en_o + ls_en_o + ls_force_o, 0);
    uv_i = 0;
    wait_ss(n);
    chk("R6 restart after uv", n, 4000);

    // External over-temperature (R9)
    to_reg();
    ot_ext_i = 1;
    tick();
    chk("R9 ext hot off", hs_en_o + ls_en_o + pgood_o, 0);
    ticks(50);
    chk("R9 ext hot held", hs_en_o + ss_start_o, 0);
    ot_ext_i = 0;
    tick();
    chk("R9 ext hot restart", ss_start_o + hs_en_o, 2);

    // Internal thermal during ramp (R9)
    tsd_i = 1;
    tick();
    chk("R9 tsd off", hs_en_o + ls_en_o, 0);
    tsd_i = 0;
    tick();
    chk("R9 tsd restart", ss_start_o, 1);

    // Disable from clamp (R1)
    to_reg();
    ov_i = 1;
    ticks(BLANK);
    ov_i = 0;
    chk("R5 clamp before disable", ls_force_o, 1);
    en_i = 0;
    tick();
    chk("R1 disable from clamp", ls_force_o + ls_en_o + hs_en_o + pgood_o, 0);
    en_i = 1;
    tick();
    chk("R2 re-enable pulse", ss_start_o, 1);

    // Lockout loss in regulation (R1)
    to_reg();
    uvlo_ok_i = 0;
    tick();
    chk("R1 uvlo loss", hs_en_o + ls_en_o + pgood_o, 0);
    uvlo_ok_i = 1;
    tick();

    // Over-current in regulation (R3)
    to_reg();
    ocp_hiccup_i = 1;
    tick();
    chk("R3 ocp in regulation", hs_en_o + pgood_o, 0);
    ocp_hiccup_i = 0;

    finish_up();
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end
endmodule